// File: doc/BRIEF.md
# Open-Row Read Buffer Controller

This block sits in front of a small behavioural data memory of 4 KB, built as four banks of 1 KB with 128-bit physical rows, and serves a host that issues 11-bit word addresses with 16-bit write and read data. Every full array read captures the whole 128-bit row into a holding register. The register remembers which bank and row it holds.

When a later read falls in the same bank and row while the holding register is valid, the word is taken straight from the register in one cycle. In that case the row-decode enable and the wordline enable stay low, which is where the energy saving comes from. The host needs no special command for this: the match is found by comparing addresses.

A read that misses runs the array for one cycle and returns data one cycle later, refilling the register. A write takes one array cycle. If the write hits the buffered row, the buffer is marked invalid, so the next read of that row goes back to the array. Each completed read reports on a status output whether it was served from the buffer or from the array.

Top module: `openrow_rd_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_done` is 0, `row_dec_en` and `wl_en` are 0, and the holding register is invalid, so the first read of any address is a full read.
- R2: The address is split into bank `addr[10:9]`, row within bank `addr[8:3]` and word within row `addr[2:0]`. A read returns the 16-bit value last written to that same address.
- R3: A read that misses the holding register asserts `row_dec_en` and `wl_en` for exactly one cycle. It then pulses `rd_done` two cycles after the request is accepted.
- R4: A read to the buffered bank and row while the buffer is valid pulses `rd_done` one cycle after acceptance, and `row_dec_en` and `wl_en` stay 0 throughout.
- R5: `rd_low_energy` is 1 together with `rd_done` for a read served from the buffer. It is 0 for a full read, and it is 0 whenever `rd_done` is 0.
- R6: After one full read of a row, reads of the other seven words of that row are each served from the buffer.
- R7: A write whose bank and row match the buffered row invalidates the buffer. A write to any other row leaves the buffer valid.
- R8: A write is accepted in one cycle, asserts `row_dec_en` and `wl_en` for one cycle, and never pulses `rd_done`.
- R9: `req_ready` is 0 in every cycle in which the array is being accessed. Requests are accepted only when `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address: bank, row, word |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller can accept a request |
| rd_done | output | 1 | One-cycle strobe: `rd_data` valid |
| rd_data | output | 16 | Read data |
| rd_low_energy | output | 1 | Completed read came from the holding register |
| row_dec_en | output | 1 | Row/bank decoder enable |
| wl_en | output | 1 | Wordline driver enable |

## Verification
A stale or wrong holding-register tag shows up on the read that follows it. That read returns a word from the wrong row, with `rd_low_energy` high and no decoder activity, which the bench sees at the very next `rd_done`. A missed invalidation after a write shows the old value on the next read of that row. A valid flag that is wrongly cleared shows as a two-cycle latency plus a decoder pulse where one cycle with none was expected. Latency and enable activity are measured on every transaction, so each such fault surfaces within two cycles of the affected request.

// File: rtl/openrow_pkg.sv
package openrow_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RDARR = 2'd1,
    ST_WRARR = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/orb_array_model.sv
module orb_array_model #(
  parameter int TAG_W  = 8,
  parameter int ROW_W  = 128,
  parameter int DATA_W = 16,
  parameter int WSEL_W = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [TAG_W-1:0]  row_idx,
  input  logic [WSEL_W-1:0] word_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [ROW_W-1:0]  row_out
);
  localparam int NROWS = 1 << TAG_W;

  logic [ROW_W-1:0] mem_q [NROWS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[row_idx][word_idx*DATA_W +: DATA_W] <= wdata;
    end
  end

  always_comb begin
    row_out = rd_en ? mem_q[row_idx] : '0;
  end
endmodule

// File: rtl/orb_row_hold.sv
module orb_row_hold #(
  parameter int TAG_W = 8,
  parameter int ROW_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] load_tag,
  input  logic [ROW_W-1:0] load_row,
  input  logic             wr_commit,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             probe_hit,
  output logic             hold_valid,
  output logic [ROW_W-1:0] hold_row
);
  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             wr_match;

  assign wr_match = valid_q && (tag_q == wr_tag);

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    row_d   = row_q;
    if (load) begin
      valid_d = 1'b1;
      tag_d   = load_tag;
      row_d   = load_row;
    end else if (wr_commit && wr_match) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      row_q   <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      row_q   <= row_d;
    end
  end

  assign probe_hit  = valid_q && (tag_q == probe_tag);
  assign hold_valid = valid_q;
  assign hold_row   = row_q;

  assert_wr_invalidates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !load && valid_q && tag_q == wr_tag) |=> !valid_q);
  assert_other_wr_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !load && valid_q && tag_q != wr_tag) |=> valid_q);
endmodule

// File: rtl/orb_word_sel.sv
module orb_word_sel #(
  parameter int ROW_W  = 128,
  parameter int DATA_W = 16
) (
  input  logic [ROW_W-1:0]                     row_in,
  input  logic [$clog2(ROW_W/DATA_W)-1:0]      sel,
  output logic [DATA_W-1:0]                    word_out
);
  localparam int NWORDS = ROW_W / DATA_W;

  logic [DATA_W-1:0] words [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_slice
    assign words[g] = row_in[g*DATA_W +: DATA_W];
  end

  assign word_out = words[sel];
endmodule

// File: rtl/openrow_rd_ctrl.sv
module openrow_rd_ctrl
  import openrow_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int ROW_W  = 128,
  parameter int BANKS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_low_energy,
  output logic              row_dec_en,
  output logic              wl_en
);
  localparam int WSEL_W    = $clog2(ROW_W / DATA_W);
  localparam int BANK_W    = $clog2(BANKS);
  localparam int TAG_W     = ADDR_W - WSEL_W;
  localparam int ROWSEL_W  = TAG_W - BANK_W;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s      <= rst_meta_q;
    end
  end

  ctrl_state_e       state_q, state_d;
  logic [TAG_W-1:0]  pend_tag_q, pend_tag_d;
  logic [WSEL_W-1:0] pend_word_q, pend_word_d;
  logic [DATA_W-1:0] pend_wdata_q, pend_wdata_d;
  logic              done_q, done_d;
  logic              le_q, le_d;
  logic [DATA_W-1:0] data_q, data_d;

  logic [TAG_W-1:0]  req_tag;
  logic [WSEL_W-1:0] req_word;
  logic              accept, probe_hit, hold_valid, arr_active;
  logic [ROW_W-1:0]  arr_row, hold_row;
  logic [DATA_W-1:0] hold_word, arr_word;

  assign req_tag  = req_addr[ADDR_W-1:WSEL_W];
  assign req_word = req_addr[WSEL_W-1:0];

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign arr_active = (state_q != ST_IDLE);
  assign row_dec_en = arr_active;
  assign wl_en      = arr_active;

  orb_array_model #(
    .TAG_W(TAG_W), .ROW_W(ROW_W), .DATA_W(DATA_W), .WSEL_W(WSEL_W)
  ) u_array (
    .clk     (clk),
    .wr_en   (state_q == ST_WRARR),
    .rd_en   (wl_en),
    .row_idx (pend_tag_q),
    .word_idx(pend_word_q),
    .wdata   (pend_wdata_q),
    .row_out (arr_row)
  );

  orb_row_hold #(.TAG_W(TAG_W), .ROW_W(ROW_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_s),
    .load      (state_q == ST_RDARR),
    .load_tag  (pend_tag_q),
    .load_row  (arr_row),
    .wr_commit (state_q == ST_WRARR),
    .wr_tag    (pend_tag_q),
    .probe_tag (req_tag),
    .probe_hit (probe_hit),
    .hold_valid(hold_valid),
    .hold_row  (hold_row)
  );

  orb_word_sel #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_sel_hold (
    .row_in  (hold_row),
    .sel     (req_word),
    .word_out(hold_word)
  );

  orb_word_sel #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_sel_arr (
    .row_in  (arr_row),
    .sel     (pend_word_q),
    .word_out(arr_word)
  );

  // next-state logic
  always_comb begin
    state_d      = state_q;
    pend_tag_d   = pend_tag_q;
    pend_word_d  = pend_word_q;
    pend_wdata_d = pend_wdata_q;
    done_d       = 1'b0;
    le_d         = 1'b0;
    data_d       = data_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          pend_tag_d   = req_tag;
          pend_word_d  = req_word;
          pend_wdata_d = req_wdata;
          if (req_write) begin
            state_d = ST_WRARR;
          end else if (probe_hit) begin
            done_d = 1'b1;
            le_d   = 1'b1;
            data_d = hold_word;
          end else begin
            state_d = ST_RDARR;
          end
        end
      end
      ST_RDARR: begin
        done_d  = 1'b1;
        data_d  = arr_word;
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q      <= ST_IDLE;
      pend_tag_q   <= '0;
      pend_word_q  <= '0;
      pend_wdata_q <= '0;
      done_q       <= 1'b0;
      le_q         <= 1'b0;
      data_q       <= '0;
    end else begin
      state_q      <= state_d;
      pend_tag_q   <= pend_tag_d;
      pend_word_q  <= pend_word_d;
      pend_wdata_q <= pend_wdata_d;
      done_q       <= done_d;
      le_q         <= le_d;
      data_q       <= data_d;
    end
  end

  assign rd_done       = done_q;
  assign rd_low_energy = le_q;
  assign rd_data       = data_q;

  assert_full_read_decoded_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_done && !rd_low_energy) |-> $past(row_dec_en && wl_en));
  assert_array_then_done_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_RDARR) |=> (rd_done && !rd_low_energy));
  assert_hit_from_valid_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_done && rd_low_energy) |-> $past(hold_valid && !row_dec_en));
  assert_status_with_done_R5: assert property (@(posedge clk) disable iff (!rst_s)
    rd_low_energy |-> rd_done);
  assert_write_no_done_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_WRARR) |=> (!rd_done && req_ready));
  assert_busy_when_active_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (row_dec_en || wl_en) |-> !req_ready);
endmodule

// File: tb/openrow_rd_ctrl_tb.sv
module openrow_rd_ctrl_tb;
  localparam int CLK_HALF = 10; // 50 MHz
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rd_done, rd_low_energy, row_dec_en, wl_en;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] shadow [2048];

  always #CLK_HALF clk = ~clk;

  openrow_rd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_done(rd_done), .rd_data(rd_data), .rd_low_energy(rd_low_energy),
    .row_dec_en(row_dec_en), .wl_en(wl_en)
  );

  // {write, addr[10:0], data[15:0], expected low-energy flag}
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 11'h000, 16'hA000, 1'b0},
    {1'b1, 11'h001, 16'hA001, 1'b0},
    {1'b1, 11'h007, 16'hA007, 1'b0},
    {1'b1, 11'h008, 16'hB008, 1'b0},
    {1'b1, 11'h608, 16'hC608, 1'b0},
    {1'b0, 11'h000, 16'h0000, 1'b0},
    {1'b0, 11'h001, 16'h0000, 1'b1},
    {1'b0, 11'h007, 16'h0000, 1'b1},
    {1'b0, 11'h008, 16'h0000, 1'b0},
    {1'b0, 11'h608, 16'h0000, 1'b0},
    {1'b0, 11'h608, 16'h0000, 1'b1},
    {1'b1, 11'h609, 16'hD609, 1'b0},
    {1'b0, 11'h609, 16'h0000, 1'b0},
    {1'b0, 11'h608, 16'h0000, 1'b1},
    {1'b1, 11'h000, 16'hE000, 1'b0},
    {1'b0, 11'h609, 16'h0000, 1'b1},
    {1'b0, 11'h000, 16'h0000, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
    shadow[a] = d;
    @(negedge clk);
    check(row_dec_en && wl_en, "R8 write decode", {row_dec_en, wl_en}, 3);
    check(!rd_done, "R8 write no done", rd_done, 0);
    check(!req_ready, "R9 busy in write", req_ready, 0);
  endtask

  task automatic do_read(input logic [10:0] a, input bit exp_le);
    int  cyc;
    bit  saw_dec;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    #1 req_valid = 1'b0;
    cyc = 0; saw_dec = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cyc++;
      if (row_dec_en || wl_en) saw_dec = 1'b1;
      if (rd_done) break;
    end
    check(rd_data == shadow[a], "R2 read data", rd_data, shadow[a]);
    check(rd_low_energy == exp_le, "R5 status", rd_low_energy, exp_le);
    if (exp_le) begin
      check(cyc == 1, "R4 hit latency", cyc, 1);
      check(!saw_dec, "R4 no decode on hit", saw_dec, 0);
    end else begin
      check(cyc == 2, "R3 miss latency", cyc, 2);
      check(saw_dec, "R3 decode on miss", saw_dec, 1);
    end
    @(negedge clk);
    check(!rd_done && !rd_low_energy, "R5 strobe one cycle", {rd_done, rd_low_energy}, 0);
  endtask

  initial begin
    #(CLK_HALF * 2 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(req_ready, "R1 ready", req_ready, 1);
    check(!rd_done && !rd_low_energy, "R1 no done", rd_done, 0);
    check(!row_dec_en && !wl_en, "R1 enables low", {row_dec_en, wl_en}, 0);

    // table walk (R2 R3 R4 R5 R7 R8)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) do_write(VEC[i][27:17], VEC[i][16:1]);
      else            do_read(VEC[i][27:17], VEC[i][0]);
    end

    // R6: fill a row, one full read then seven buffered reads
    for (int w = 0; w < 8; w++) do_write(11'h2A8 + 11'(w), 16'h5500 + 16'(w));
    do_read(11'h2AB, 1'b0);
    for (int w = 0; w < 8; w++) begin
      if (w != 3) do_read(11'h2A8 + 11'(w), 1'b1);
    end

    // R9: request held during array access is not taken twice
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h000;
    @(negedge clk);
    check(!req_ready, "R9 not ready during access", req_ready, 0);
    req_valid = 1'b0;
    @(negedge clk);
    check(rd_done && rd_data == shadow[11'h000], "R9 single completion", rd_data, shadow[11'h000]);
    @(negedge clk);
    check(!rd_done && !row_dec_en, "R9 no second access", {rd_done, row_dec_en}, 0);

    // R1: reset clears the buffer; re-read of the buffered row is a full read
    do_read(11'h001, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(11'h001, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule